// File: doc/BRIEF.md
# DMX512 Frame Timing Generator

This block drives a DMX512 serial line from an external slot buffer. Each frame opens with a break and a mark-after-break. The start code follows, and then a programmable number of data slots. Every slot goes out at 250 kbaud in 8N2 form. Software supplies three values: the data slot count, an extra gap inserted between slots, and the break-to-break refresh period, both of the latter in microseconds. The block latches all three at the start of every break.

Every timing event is derived from a microsecond tick, which is divided down from the core clock. The generator fetches slot bytes through a plain read port. It presents the address of the next data slot well ahead of the moment it samples the byte, so a synchronous memory with a one-cycle read latency can sit behind the port. If the requested period is too short for the programmed slots and gaps, the next break starts as soon as the last stop bit ends. A single enable input starts generation. When the enable is removed, the frame in flight completes and the line then stays high.

Top module: `dmx_frame_gen`

## Requirements
- R1: Out of reset, and for as long as generation has not been enabled, `dmx_o` is 1 and `buf_addr_o` is 0.
- R2: Every frame begins with `dmx_o` low for exactly 176 µs. A 12 µs high mark-after-break follows before the first start bit.
- R3: The first slot after the mark is the start code 0x00. It is followed by data slots read from buffer addresses 0, 1, … N-1 in that order. `buf_addr_o` shows the address of the next data slot from the previous slot start (or from the break, for address 0) until that slot's start bit, and `buf_data_i` is sampled at that start bit.
- R4: Each slot is 11 bit cells of 4 µs each: a low start bit, 8 data bits least significant bit first, and two high stop bits.
- R5: With gap value G, start bits of consecutive slots in a frame are exactly 44+G µs apart, and the line is high during the gap. G=0 gives 44 µs.
- R6: With period value P, consecutive breaks start exactly P µs apart when P ≥ 188 + 44·(N+1) + G·N.
- R7: When P is smaller than that sum, the next break starts exactly at the sum, that is, right at the end of the last stop bit.
- R8: Slot count, gap and period are captured at the start of each break. Changes made during a frame affect only the following frame.
- R9: With `enable_i` high, a break starts within CLK_PER_US clock cycles of leaving the idle state. After `enable_i` falls, the current frame completes with all its slots, and no further break begins while `enable_i` stays low.
- R10: A slot count of 0 produces frames that contain only the start code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, CLK_PER_US cycles per µs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Generation enable |
| slot_count_i | input | SLOT_W | Number of data slots per frame, start code excluded |
| gap_us_i | input | GAP_W | Extra interslot time in µs |
| period_us_i | input | PERIOD_W | Break-to-break period in µs |
| buf_addr_o | output | SLOT_W | Slot buffer read address |
| buf_data_i | input | 8 | Slot buffer read data |
| dmx_o | output | 1 | Serial DMX line, idle high |

## Verification
The assertions check on every cycle that the line is high whenever no break or slot is active, that start bits are low and stop bits high, that every break lasts 176 ticks, that the read address never passes the latched slot count, and that the block stays idle while disabled. The frame-level numbers come only from the bench's scenarios, which decode the line: slot contents and bit order, start-to-start spacing with and without a gap, the exact break-to-break period, its stretching, the point at which parameters are latched, and the frame that completes after the enable is removed.

// File: rtl/dmx_gen_pkg.sv
package dmx_gen_pkg;
  localparam int BREAK_US  = 176;
  localparam int MAB_US    = 12;
  localparam int BIT_US    = 4;
  localparam int SLOT_BITS = 11;
  localparam int HDR_US    = BREAK_US + MAB_US;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BREAK,
    ST_MAB,
    ST_SLOT,
    ST_GAP,
    ST_WAIT
  } gen_state_e;
endpackage

// File: rtl/dmx_us_tick.sv
module dmx_us_tick #(
  parameter int CLK_PER_US = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/dmx_slot_ser.sv
module dmx_slot_ser
  import dmx_gen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       line_o,
  output logic       done_o
);
  localparam int BW = $clog2(SLOT_BITS);
  localparam int UW = $clog2(BIT_US);

  logic [SLOT_BITS-1:0] sh_q;
  logic [BW-1:0]        bit_q;
  logic [UW-1:0]        us_q;
  logic                 busy_q;

  assign done_o = tick_i && busy_q && (bit_q == BW'(SLOT_BITS - 1)) && (us_q == UW'(BIT_US - 1));
  assign line_o = sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      bit_q  <= '0;
      us_q   <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= {2'b11, data_i, 1'b0};
      bit_q  <= '0;
      us_q   <= '0;
      busy_q <= 1'b1;
    end else if (tick_i && busy_q) begin
      if (us_q == UW'(BIT_US - 1)) begin
        us_q <= '0;
        if (bit_q == BW'(SLOT_BITS - 1)) begin
          busy_q <= 1'b0;
          sh_q   <= '1;
        end else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= {1'b1, sh_q[SLOT_BITS-1:1]};
        end
      end else begin
        us_q <= us_q + 1'b1;
      end
    end
  end

  p_start_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && bit_q == '0) |-> !line_o);
  p_stop_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && bit_q >= BW'(SLOT_BITS - 2)) |-> line_o);
endmodule

// File: rtl/dmx_frame_ctl.sv
module dmx_frame_ctl
  import dmx_gen_pkg::*;
#(
  parameter int SLOT_W   = 10,
  parameter int GAP_W    = 16,
  parameter int PERIOD_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                enable_i,
  input  logic [SLOT_W-1:0]   slot_count_i,
  input  logic [GAP_W-1:0]    gap_us_i,
  input  logic [PERIOD_W-1:0] period_us_i,
  input  logic [7:0]          buf_data_i,
  input  logic                ser_done_i,
  output logic [SLOT_W-1:0]   buf_addr_o,
  output logic                ser_load_o,
  output logic [7:0]          ser_data_o,
  output logic                in_break_o,
  output gen_state_e          state_o
);
  localparam int DUR_W = (GAP_W > 8) ? GAP_W : 8;
  localparam int ELW   = PERIOD_W + 1;

  gen_state_e          st_q, st_d;
  logic [DUR_W-1:0]    dur_q, dur_d;
  logic [SLOT_W-1:0]   slot_q, slot_d;
  logic [ELW-1:0]      el_q, el_d;
  logic [SLOT_W-1:0]   n_q;
  logic [GAP_W-1:0]    gap_q;
  logic [PERIOD_W-1:0] per_q;
  logic                go_brk;
  logic [ELW:0]        el_inc;
  logic                per_met;

  assign el_inc  = {1'b0, el_q} + 1'b1;
  assign per_met = el_inc >= (ELW+1)'(per_q);

  always_comb begin
    st_d       = st_q;
    dur_d      = dur_q;
    slot_d     = slot_q;
    el_d       = el_q;
    ser_load_o = 1'b0;
    go_brk     = 1'b0;
    if (tick_i && !(&el_q)) el_d = el_q + 1'b1;
    unique case (st_q)
      ST_IDLE: if (tick_i && enable_i) go_brk = 1'b1;
      ST_BREAK: if (tick_i) begin
        if (dur_q == '0) begin
          st_d  = ST_MAB;
          dur_d = DUR_W'(MAB_US - 1);
        end else dur_d = dur_q - 1'b1;
      end
      ST_MAB: if (tick_i) begin
        if (dur_q == '0) begin
          st_d       = ST_SLOT;
          ser_load_o = 1'b1;
        end else dur_d = dur_q - 1'b1;
      end
      ST_SLOT: if (ser_done_i) begin
        if (slot_q < n_q) begin
          if (gap_q == '0) begin
            ser_load_o = 1'b1;
            slot_d     = slot_q + 1'b1;
          end else begin
            st_d  = ST_GAP;
            dur_d = DUR_W'(gap_q) - 1'b1;
          end
        end else if (!enable_i) st_d = ST_IDLE;
        else if (per_met)       go_brk = 1'b1;
        else                    st_d = ST_WAIT;
      end
      ST_GAP: if (tick_i) begin
        if (dur_q == '0) begin
          st_d       = ST_SLOT;
          ser_load_o = 1'b1;
          slot_d     = slot_q + 1'b1;
        end else dur_d = dur_q - 1'b1;
      end
      ST_WAIT: if (tick_i) begin
        if (!enable_i)    st_d = ST_IDLE;
        else if (per_met) go_brk = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (go_brk) begin
      st_d   = ST_BREAK;
      dur_d  = DUR_W'(BREAK_US - 1);
      el_d   = '0;
      slot_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      dur_q  <= '0;
      slot_q <= '0;
      el_q   <= '0;
      n_q    <= '0;
      gap_q  <= '0;
      per_q  <= '0;
    end else begin
      st_q   <= st_d;
      dur_q  <= dur_d;
      slot_q <= slot_d;
      el_q   <= el_d;
      if (go_brk) begin
        n_q   <= slot_count_i;
        gap_q <= gap_us_i;
        per_q <= period_us_i;
      end
    end
  end

  assign buf_addr_o = slot_q;
  assign ser_data_o = (st_q == ST_MAB) ? 8'h00 : buf_data_i;
  assign in_break_o = (st_q == ST_BREAK);
  assign state_o    = st_q;

  // break length checker
  logic [7:0] brk_ticks_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               brk_ticks_q <= '0;
    else if (st_q != ST_BREAK) brk_ticks_q <= '0;
    else if (tick_i)           brk_ticks_q <= brk_ticks_q + 1'b1;
  end

  p_break_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MAB && $past(st_q) == ST_BREAK) |-> brk_ticks_q == 8'(BREAK_US));
  p_addr_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= n_q);
  p_stay_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !enable_i) |=> st_q == ST_IDLE);
endmodule

// File: rtl/dmx_frame_gen.sv
module dmx_frame_gen
  import dmx_gen_pkg::*;
#(
  parameter int CLK_PER_US = 2,
  parameter int SLOT_W     = 10,
  parameter int GAP_W      = 16,
  parameter int PERIOD_W   = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic [SLOT_W-1:0]   slot_count_i,
  input  logic [GAP_W-1:0]    gap_us_i,
  input  logic [PERIOD_W-1:0] period_us_i,
  output logic [SLOT_W-1:0]   buf_addr_o,
  input  logic [7:0]          buf_data_i,
  output logic                dmx_o
);
  logic       tick;
  logic       ser_load, ser_done, ser_line, in_break;
  logic [7:0] ser_data;
  gen_state_e state;

  dmx_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  dmx_frame_ctl #(
    .SLOT_W  (SLOT_W),
    .GAP_W   (GAP_W),
    .PERIOD_W(PERIOD_W)
  ) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .enable_i    (enable_i),
    .slot_count_i(slot_count_i),
    .gap_us_i    (gap_us_i),
    .period_us_i (period_us_i),
    .buf_data_i  (buf_data_i),
    .ser_done_i  (ser_done),
    .buf_addr_o  (buf_addr_o),
    .ser_load_o  (ser_load),
    .ser_data_o  (ser_data),
    .in_break_o  (in_break),
    .state_o     (state)
  );

  dmx_slot_ser u_ser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .load_i(ser_load),
    .data_i(ser_data),
    .line_o(ser_line),
    .done_o(ser_done)
  );

  assign dmx_o = ser_line & ~in_break;

  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE || state == ST_MAB || state == ST_GAP || state == ST_WAIT) |-> dmx_o);
endmodule

// File: tb/tb_dmx_frame_gen.sv
module tb_dmx_frame_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int SLOT_W     = 10;
  localparam int GAP_W      = 16;
  localparam int PERIOD_W   = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [SLOT_W-1:0]   slot_count = '0;
  logic [GAP_W-1:0]    gap_us = '0;
  logic [PERIOD_W-1:0] period_us = '0;
  logic [SLOT_W-1:0]   buf_addr;
  logic [7:0]          buf_data;
  logic                dmx;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  dmx_frame_gen #(
    .CLK_PER_US(CPU), .SLOT_W(SLOT_W), .GAP_W(GAP_W), .PERIOD_W(PERIOD_W)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable),
    .slot_count_i(slot_count), .gap_us_i(gap_us), .period_us_i(period_us),
    .buf_addr_o(buf_addr), .buf_data_i(buf_data), .dmx_o(dmx)
  );

  function automatic logic [7:0] pat(int a);
    return 8'(a * 37 + 11) ^ 8'hA5;
  endfunction

  assign buf_data = pat(int'(buf_addr));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_level(logic v, output int t);
    do @(negedge clk); while (dmx !== v);
    t = cyc;
  endtask

  task automatic wait_until(int c);
    do @(negedge clk); while (cyc < c);
  endtask

  task automatic start(int n, int gap, int p, output int t_brk);
    int c;
    slot_count = SLOT_W'(n);
    gap_us     = GAP_W'(gap);
    period_us  = PERIOD_W'(p);
    @(negedge clk);
    enable = 1'b1;
    c = cyc;
    wait_level(1'b0, t_brk);
    chk((t_brk - c) <= CPU, "R9", "start latency cycles", t_brk - c, CPU);
  endtask

  // decode one frame whose break fell at t_brk; p<0 means no next break expected
  task automatic capture(int n, int gap, int p, inout int t_brk);
    int t, t_mab, prev, exp_p, content, lows;
    logic [10:0] bits;
    wait_level(1'b1, t);
    chk(t - t_brk == 176*CPU, "R2", "break cycles", t - t_brk, 176*CPU);
    t_mab = t;
    wait_level(1'b0, t);
    chk(t - t_mab == 12*CPU, "R2", "mab cycles", t - t_mab, 12*CPU);
    prev = t;
    for (int k = 0; k <= n; k++) begin
      if (k > 0) begin
        wait_level(1'b0, t);
        chk(t - prev == (44+gap)*CPU, "R5", "start spacing", t - prev, (44+gap)*CPU);
        prev = t;
      end
      for (int i = 0; i < 11; i++) begin
        wait_until(t + (4*i+2)*CPU);
        bits[i] = dmx;
      end
      chk(bits[0] == 1'b0 && bits[10:9] == 2'b11, "R4", "start/stop bits", bits, 11'h601);
      if (k == 0) chk(bits[8:1] == 8'h00, "R3", "start code", bits[8:1], 0);
      else        chk(bits[8:1] == pat(k-1), "R3", "data slot", bits[8:1], pat(k-1));
    end
    content = 188 + 44*(n+1) + gap*n;
    if (p >= 0) begin
      exp_p = (p > content) ? p : content;
      wait_level(1'b0, t);
      if (p >= content) chk(t - t_brk == exp_p*CPU, "R6", "period cycles", t - t_brk, exp_p*CPU);
      else              chk(t - t_brk == exp_p*CPU, "R7", "stretched period", t - t_brk, exp_p*CPU);
      t_brk = t;
    end else begin
      lows = 0;
      t = cyc;
      while (cyc < t + 1200*CPU) begin
        @(negedge clk);
        if (dmx !== 1'b1) lows++;
      end
      chk(lows == 0, "R9", "low samples after disable", lows, 0);
    end
  endtask

  task automatic settle();
    int hi;
    enable = 1'b0;
    hi = 0;
    while (hi < 400) begin
      @(negedge clk);
      if (dmx === 1'b1) hi++; else hi = 0;
    end
  endtask

  task automatic t_reset();
    int bad;
    #(CLK_PERIOD*3);
    chk(dmx === 1'b1, "R1", "line in reset", dmx, 1);
    @(negedge clk); rst_n = 1'b1;
    bad = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (dmx !== 1'b1 || buf_addr !== '0) bad++;
    end
    chk(bad == 0, "R1", "idle samples not high/addr0", bad, 0);
  endtask

  task automatic t_basic();
    int tb_;
    start(4, 0, 600, tb_);
    capture(4, 0, 600, tb_);
    capture(4, 0, 600, tb_);
    settle();
  endtask

  task automatic t_gap();
    int tb_;
    start(3, 10, 1000, tb_);
    capture(3, 10, 1000, tb_);
    settle();
  endtask

  task automatic t_stretch();
    int tb_;
    start(6, 5, 100, tb_);
    capture(6, 5, 100, tb_);
    capture(6, 5, 100, tb_);
    settle();
  endtask

  task automatic t_latch();
    int tb_;
    start(2, 0, 500, tb_);
    slot_count = SLOT_W'(5);  // R8: new count only in the following frame
    gap_us     = GAP_W'(3);
    capture(2, 0, 500, tb_);
    capture(5, 3, 500, tb_);
    settle();
  endtask

  task automatic t_disable();
    int tb_;
    start(3, 0, 400, tb_);
    enable = 1'b0;  // R9: frame in flight still completes
    capture(3, 0, -1, tb_);
    settle();
  endtask

  task automatic t_zero();
    int tb_;
    start(0, 0, 0, tb_);
    capture(0, 0, 0, tb_);  // R10: start code only, period 232
    capture(0, 0, 0, tb_);
    settle();
  endtask

  initial begin
    t_reset();
    t_basic();
    t_gap();
    t_stretch();
    t_latch();
    t_disable();
    t_zero();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule